// File: doc/BRIEF.md
# Priority Ternary CAM Lookup

This block is a small ternary lookup table for forwarding decisions. Each entry has three parts: a pattern, a valid flag and a result word, such as an egress port. Every pattern bit is one of three states: zero, one or wildcard. Wildcard bits let a single entry stand for a whole family of keys. A write port loads one entry per cycle.

A search port presents a key. The key is compared against every entry at once. The registered outputs give a hit flag, the index of the winning entry and the result word of that entry.

When more than one entry matches, the entry with the lowest index wins. Software places the most specific routes at low indices. An entry that is wildcard in every bit, placed last, works as a default route. Patterns that contain the reserved code are stored, but they can never match, and the write that loads one is flagged.

Top module: `tcam_lookup`

## Requirements
- R1: Pattern bit i is held in `wr_pattern[2i+1:2i]`. Code 2'b01 requires a key bit of 0, code 2'b10 requires a key bit of 1, and code 2'b00 is a wildcard.
- R2: An entry matches only when it is valid and every non-wildcard bit equals the corresponding key bit.
- R3: A valid entry with every bit coded 2'b00 matches any key.
- R4: When several entries match, `hit_idx` and `hit_result` come from the lowest-index matching entry.
- R5: An entry written with `wr_valid` low never matches, whatever its pattern.
- R6: An entry that holds code 2'b11 in any bit never matches any key.
- R7: `wr_err` is high in the cycle after a write whose pattern contains code 2'b11. It is low after any other cycle.
- R8: Search outputs update one clock edge after a cycle in which `srch_en` is high. They hold their value while `srch_en` is low.
- R9: A write changes the result only for searches presented in later cycles. A search presented in the same cycle as the write sees the old contents.
- R10: When a search finds no match, `hit` is 0, `hit_idx` is 0 and `hit_result` is 0.
- R11: After reset every entry is invalid, and `hit`, `hit_idx`, `hit_result` and `wr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | IDX_W | Entry index to write |
| wr_pattern | input | 2*KEY_W | Ternary pattern, two bits per key bit |
| wr_valid | input | 1 | Valid flag stored with the entry |
| wr_result | input | RES_W | Result word stored with the entry |
| wr_err | output | 1 | Previous write held the reserved code |
| srch_en | input | 1 | Search with `srch_key` this cycle |
| srch_key | input | KEY_W | Lookup key |
| hit | output | 1 | Last search matched an entry |
| hit_idx | output | IDX_W | Index of the winning entry |
| hit_result | output | RES_W | Result word of the winning entry |

## Verification
The directed cases each isolate one part of the lookup:
- An exact-match entry tried with its own key and with a key one bit away shows that care bits are compared.
- An entry that is wildcard in its low byte, placed at a lower index than the exact entry, shows both wildcard matching and lowest-index priority.
- An all-wildcard last entry shows default-route behaviour, and an invalid all-wildcard entry shows that the valid flag gates matching.
- An entry carrying the reserved code shows both the error flag and the suppressed match.

A random phase then draws keys from stored patterns, so that overlapping hits happen often. It also mixes writes into the same cycle as searches, which exercises write-then-search ordering against a behavioural table model.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef logic [1:0] tbit_t;

  localparam tbit_t TB_DC   = 2'b00;
  localparam tbit_t TB_ZERO = 2'b01;
  localparam tbit_t TB_ONE  = 2'b10;
  localparam tbit_t TB_BAD  = 2'b11;

  // One ternary bit against one key bit; the reserved code never agrees.
  function automatic logic tbit_hit(tbit_t code, logic kbit);
    logic ok;
    case (code)
      TB_DC:   ok = 1'b1;
      TB_ZERO: ok = ~kbit;
      TB_ONE:  ok = kbit;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  parameter int RES_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PAT_W  = 2 * KEY_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [PAT_W-1:0]                  wr_pattern,
  input  logic                              wr_valid,
  input  logic [RES_W-1:0]                  wr_result,
  output logic [ENTRIES-1:0][PAT_W-1:0]     pat_q,
  output logic [ENTRIES-1:0]                vld_q,
  output logic [ENTRIES-1:0][RES_W-1:0]     res_q
);

  logic [ENTRIES-1:0] sel;
  logic [ENTRIES-1:0] vld_d;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign sel[e] = wr_en && (wr_idx == IDX_W'(e));

      // Pattern and result words carry no reset: the valid flag guards them.
      always_ff @(posedge clk) begin
        if (sel[e]) begin
          pat_q[e] <= wr_pattern;
          res_q[e] <= wr_result;
        end
      end

      // R9: a write lands in the selected entry at the next edge
      p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel[e] |=> (vld_q[e] == $past(wr_valid)));
    end
  endgenerate

  always_comb begin
    vld_d = vld_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (sel[e]) vld_d[e] = wr_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  localparam int PAT_W  = 2 * KEY_W
) (
  input  logic [KEY_W-1:0]              key,
  input  logic [ENTRIES-1:0][PAT_W-1:0] pat,
  input  logic [ENTRIES-1:0]            vld,
  output logic [ENTRIES-1:0]            match_vec
);

  logic [ENTRIES-1:0][KEY_W-1:0] bit_ok;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      for (genvar b = 0; b < KEY_W; b++) begin : g_bit
        assign bit_ok[e][b] = tcam_pkg::tbit_hit(pat[e][2*b +: 2], key[b]);
      end
      assign match_vec[e] = vld[e] & (&bit_ok[e]);
    end
  endgenerate

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int ENTRIES = 16,
  parameter int RES_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            req,
  input  logic [ENTRIES-1:0][RES_W-1:0] res,
  output logic                          any,
  output logic [IDX_W-1:0]              idx,
  output logic [RES_W-1:0]              res_sel
);

  logic [ENTRIES-1:0] grant;

  // Isolate the lowest set request bit.
  assign grant = req & (~req + ENTRIES'(1));
  assign any   = |req;

  always_comb begin
    idx     = '0;
    res_sel = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant[e]) idx = idx | IDX_W'(e);
      res_sel = res_sel | ({RES_W{grant[e]}} & res[e]);
    end
  end

  // R4: at most one winner, and it is a real request
  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  parameter int RES_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PAT_W  = 2 * KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PAT_W-1:0] wr_pattern,
  input  logic             wr_valid,
  input  logic [RES_W-1:0] wr_result,
  output logic             wr_err,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [RES_W-1:0] hit_result
);

  logic [ENTRIES-1:0][PAT_W-1:0] pat_q;
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][RES_W-1:0] res_q;
  logic [ENTRIES-1:0]            match_vec;
  logic                          win_any;
  logic [IDX_W-1:0]              win_idx;
  logic [RES_W-1:0]              win_res;

  logic             hit_d;
  logic [IDX_W-1:0] idx_d;
  logic [RES_W-1:0] res_d;
  logic             bad_code;
  logic             err_d;

  tcam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_pattern (wr_pattern),
    .wr_valid   (wr_valid),
    .wr_result  (wr_result),
    .pat_q      (pat_q),
    .vld_q      (vld_q),
    .res_q      (res_q)
  );

  tcam_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
    .key       (srch_key),
    .pat       (pat_q),
    .vld       (vld_q),
    .match_vec (match_vec)
  );

  tcam_prio #(.ENTRIES(ENTRIES), .RES_W(RES_W)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (match_vec),
    .res     (res_q),
    .any     (win_any),
    .idx     (win_idx),
    .res_sel (win_res)
  );

  // Write-side check for the reserved code.
  always_comb begin
    bad_code = 1'b0;
    for (int b = 0; b < KEY_W; b++) begin
      if (wr_pattern[2*b +: 2] == tcam_pkg::TB_BAD) bad_code = 1'b1;
    end
    err_d = wr_en & bad_code;
  end

  // Next state of the search outputs; the clock enable is srch_en.
  always_comb begin
    hit_d = hit;
    idx_d = hit_idx;
    res_d = hit_result;
    if (srch_en) begin
      hit_d = win_any;
      idx_d = win_idx;
      res_d = win_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit        <= 1'b0;
      hit_idx    <= '0;
      hit_result <= '0;
      wr_err     <= 1'b0;
    end else begin
      hit        <= hit_d;
      hit_idx    <= idx_d;
      hit_result <= res_d;
      wr_err     <= err_d;
    end
  end

  // R8: a search reports whether any entry matched in its cycle
  p_hit_follows_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> (hit == $past(|match_vec)));

  // R8: idle cycles leave the outputs untouched
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> $stable({hit, hit_idx, hit_result}));

  // R10: a miss reports zero index and zero result
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && hit_result == '0));

  // R7: the error flag only follows a write
  p_err_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));

endmodule

// File: tb/tcam_lookup_tb.sv
module tcam_lookup_tb;

  localparam int ENTRIES = 16;
  localparam int KEY_W   = 16;
  localparam int RES_W   = 8;
  localparam int IDX_W   = 4;
  localparam int PAT_W   = 2 * KEY_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [PAT_W-1:0] wr_pattern;
  logic             wr_valid;
  logic [RES_W-1:0] wr_result;
  logic             wr_err;
  logic             srch_en;
  logic [KEY_W-1:0] srch_key;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [RES_W-1:0] hit_result;

  always #4 clk = ~clk;

  tcam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_pattern(wr_pattern), .wr_valid(wr_valid), .wr_result(wr_result),
    .wr_err(wr_err), .srch_en(srch_en), .srch_key(srch_key),
    .hit(hit), .hit_idx(hit_idx), .hit_result(hit_result)
  );

  int total = 0;
  int bad   = 0;

  // Behavioural table model
  logic [PAT_W-1:0] m_pat [ENTRIES];
  logic             m_vld [ENTRIES];
  logic [RES_W-1:0] m_res [ENTRIES];
  logic             e_hit;
  int               e_idx;
  logic [RES_W-1:0] e_res;
  logic             e_err;

  function automatic logic [PAT_W-1:0] mk(input logic [KEY_W-1:0] care,
                                          input logic [KEY_W-1:0] val);
    logic [PAT_W-1:0] p;
    for (int b = 0; b < KEY_W; b++)
      p[2*b +: 2] = !care[b] ? 2'b00 : (val[b] ? 2'b10 : 2'b01);
    return p;
  endfunction

  function automatic logic entry_ok(input int e, input logic [KEY_W-1:0] k);
    if (!m_vld[e]) return 1'b0;
    for (int b = 0; b < KEY_W; b++) begin
      case (m_pat[e][2*b +: 2])
        2'b00: ;
        2'b01: if (k[b] != 1'b0) return 1'b0;
        2'b10: if (k[b] != 1'b1) return 1'b0;
        default: return 1'b0;
      endcase
    end
    return 1'b1;
  endfunction

  function automatic logic has_bad(input logic [PAT_W-1:0] p);
    for (int b = 0; b < KEY_W; b++)
      if (p[2*b +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag);
    total++;
    if (hit !== e_hit || int'(hit_idx) != e_idx || hit_result !== e_res || wr_err !== e_err) begin
      bad++;
      $display("FAIL %s: actual hit=%0b idx=%0d res=%0h err=%0b expected hit=%0b idx=%0d res=%0h err=%0b",
               tag, hit, hit_idx, hit_result, wr_err, e_hit, e_idx, e_res, e_err);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic we, input int idx, input logic [PAT_W-1:0] pat,
                      input logic val, input logic [RES_W-1:0] res,
                      input logic se, input logic [KEY_W-1:0] key, input string tag);
    wr_en = we; wr_idx = IDX_W'(idx); wr_pattern = pat; wr_valid = val;
    wr_result = res; srch_en = se; srch_key = key;
    @(posedge clk);
    // R9: search sees the table as it stood before this edge's write
    if (se) begin
      e_hit = 1'b0; e_idx = 0; e_res = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (!e_hit && entry_ok(e, key)) begin
          e_hit = 1'b1; e_idx = e; e_res = m_res[e];
        end
      end
    end
    e_err = we && has_bad(pat);
    if (we) begin
      m_pat[idx] = pat; m_vld[idx] = val; m_res[idx] = res;
    end
    @(negedge clk);
    check(tag);
  endtask

  logic [PAT_W-1:0] dc_all;
  logic [PAT_W-1:0] badpat;

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < ENTRIES; e++) begin
      m_pat[e] = '0; m_vld[e] = 1'b0; m_res[e] = '0;
    end
    e_hit = 0; e_idx = 0; e_res = '0; e_err = 0;
    rst_n = 1'b0; wr_en = 0; wr_idx = '0; wr_pattern = '0; wr_valid = 0;
    wr_result = '0; srch_en = 0; srch_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 reset outputs");
    step(0, 0, '0, 0, 0, 1, 16'h1234, "R11 empty table misses");
    dc_all = mk(16'h0000, 16'h0000);

    step(1, 5, mk(16'hFFFF, 16'h1234), 1, 8'h33, 1, 16'h1234, "R9 same-cycle search sees old table");
    step(0, 0, '0, 0, 0, 1, 16'h1234, "R2 exact hit");
    step(0, 0, '0, 0, 0, 1, 16'h1235, "R10 one bit off misses");
    step(1, 2, mk(16'hFF00, 16'h1200), 1, 8'h77, 0, 16'h1234, "R8 hold while idle");
    step(0, 0, '0, 0, 0, 1, 16'h1234, "R4 lower index wins");
    step(0, 0, '0, 0, 0, 1, 16'h12AB, "R1 wildcard low byte");
    step(0, 0, '0, 0, 0, 1, 16'h1334, "R2 care bit differs");
    step(1, 15, dc_all, 1, 8'h99, 0, 16'h0, "R8 hold across write");
    step(0, 0, '0, 0, 0, 1, 16'hABCD, "R3 default route");
    step(0, 0, '0, 0, 0, 1, 16'h1234, "R4 specific beats default");
    step(1, 1, dc_all, 0, 8'h11, 0, 16'h0, "R5 write invalid entry");
    step(0, 0, '0, 0, 0, 1, 16'h5555, "R5 invalid entry ignored");
    badpat = dc_all; badpat[7:6] = 2'b11;
    step(1, 0, badpat, 1, 8'h44, 0, 16'h0, "R7 error flag");
    step(0, 0, '0, 0, 0, 1, 16'h0000, "R6 reserved code never matches");
    step(0, 0, '0, 0, 0, 1, 16'h0008, "R6 reserved code either key bit");
    step(1, 0, dc_all, 1, 8'h44, 1, 16'h0000, "R7 legal write clears flag");
    step(0, 0, '0, 0, 0, 1, 16'h1234, "R4 entry zero wins");
    step(0, 0, '0, 0, 0, 0, 16'hFFFF, "R8 idle key change");

    for (int n = 0; n < 600; n++) begin
      logic [PAT_W-1:0] p;
      logic [KEY_W-1:0] k;
      int src;
      for (int b = 0; b < KEY_W; b++) begin
        int r;
        r = $urandom % 8;
        p[2*b +: 2] = (r < 2) ? 2'b01 : (r < 4) ? 2'b10 : 2'b00;
      end
      if ($urandom % 10 == 0) p[2*($urandom % KEY_W) +: 2] = 2'b11;
      src = $urandom % ENTRIES;
      for (int b = 0; b < KEY_W; b++)
        k[b] = (m_pat[src][2*b +: 2] == 2'b10) ? 1'b1 :
               (m_pat[src][2*b +: 2] == 2'b01) ? 1'b0 : 1'($urandom % 2);
      step(1'($urandom % 3 == 0), $urandom % ENTRIES, p, 1'($urandom % 5 != 0),
           RES_W'($urandom), 1'($urandom % 4 != 0), k, "R2 random lookup");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule